// File: doc/BRIEF.md
# Burst DMA Handshake Controller

This block moves packet payload between an endpoint packet buffer and an external memory using a request/acknowledge handshake. It raises a request when it is enabled and the buffer side has work, and moves one byte on each falling edge of the read or write strobe that arrives while the acknowledge is held low. Transfers are grouped into bursts of 1, 4, 8 or 16. After the final strobe of a burst the request drops, and it returns once that strobe has been released, provided the buffer can still supply or accept data.

Each buffer begins with a reserved byte at offset 0 and a length byte at offset 1, and the payload starts at offset 2. The block reaches the buffer through a byte port with an asynchronous read. It touches only the payload bytes. In the memory-to-buffer direction it validates the packet when the byte count reaches the maximum packet size. In the buffer-to-memory direction it reads the length byte first and releases the buffer once that many bytes have been sent. A low terminate input sampled during an acknowledged strobe also ends the transfer.

Every end of transfer sets a sticky end-of-transfer flag. It also clears the enable bit unless auto-reload is set, in which case a new transfer starts by itself.

Top module: `dma_burst_ctrl`

## Requirements
- R1: Config bits [1:0] set the burst length: 00 gives 1 transfer, 01 gives 4, 10 gives 8 and 11 gives 16. The request is low in the cycle after the final strobe of a burst falls. It is high again in the cycle after the strobe is seen high, if the request conditions still hold.
- R2: The request is high only while enable (config bit 2) is set and `buf_ready_i` is high.
- R3: One byte moves on each falling edge of the selected strobe while `dack_n_i` is low. The strobe is `rd_n_i` when direction is 0 and `wr_n_i` when direction is 1. A falling strobe with `dack_n_i` high moves nothing and does not advance the byte count.
- R4: Payload bytes are addressed from buffer offset 2 upward. Offsets 0 and 1 are never written.
- R5: With direction = 1 (config bit 3), the byte that brings the count to MAX_PKT pulses `buf_validate_o` with `buf_len_o` = MAX_PKT, and the transfer ends.
- R6: When `eot_n_i` is low during an acknowledged strobe, that byte still moves and the transfer ends. With direction = 1, `buf_validate_o` pulses with the number of bytes moved so far.
- R7: At the end of a transfer the enable bit is cleared if auto-reload (config bit 4) is 0. If auto-reload is 1, the enable bit stays set and the request returns with the count restarted at offset 2.
- R8: Every end of transfer sets `eot_irq_o`. The flag stays set until `irq_clr_i` is pulsed, and a new end of transfer in the same cycle as the clear takes priority.
- R9: With direction = 0, the length byte is read from offset 1 (capped at MAX_PKT) before any request. `buf_release_o` pulses together with the strobe of the last payload byte. A length of 0 pulses `buf_release_o` at once, without a request and without setting the flag.
- R10: A config write loads all five bits, returns the block to idle and restarts the byte and burst counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_wdata_i | input | 5 | Config value: burst[1:0], enable[2], direction[3], auto-reload[4] |
| cfg_o | output | 5 | Live config, including the self-cleared enable |
| dreq_o | output | 1 | Transfer request |
| dack_n_i | input | 1 | Acknowledge, active low |
| rd_n_i | input | 1 | Read strobe, active low (buffer to memory) |
| wr_n_i | input | 1 | Write strobe, active low (memory to buffer) |
| eot_n_i | input | 1 | Terminate, active low |
| mem_rdata_o | output | 8 | Byte presented to memory |
| mem_wdata_i | input | 8 | Byte from memory |
| buf_ready_i | input | 1 | Buffer holds a packet (dir 0) or has a free bank (dir 1) |
| buf_addr_o | output | 8 | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer byte at `buf_addr_o` |
| buf_rd_o | output | 1 | Payload byte consumed |
| buf_wr_o | output | 1 | Write buffer byte |
| buf_wdata_o | output | 8 | Byte written to buffer |
| buf_validate_o | output | 1 | Mark written packet valid |
| buf_len_o | output | 8 | Packet length with validate |
| buf_release_o | output | 1 | Free the read packet |
| eot_irq_o | output | 1 | End-of-transfer flag |
| irq_clr_i | input | 1 | Clear the flag |

## Verification
A byte count that is off by one shows at the ports on the very next strobe, as the wrong buffer address. It also moves the validate or release pulse a strobe early or late. A burst counter that has slipped shows within one burst, because the request drops after the wrong strobe. An enable or end-of-transfer state that was not updated shows in the cycle after the last byte: the request stays high, the config readback keeps its enable, or the flag stays low.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE} dma_st_e;

  localparam logic [7:0] LEN_OFS = 8'd1;
  localparam logic [7:0] PAY_OFS = 8'd2;

  function automatic logic [4:0] burst_len(input logic [1:0] code);
    case (code)
      2'b00:   burst_len = 5'd1;
      2'b01:   burst_len = 5'd4;
      2'b10:   burst_len = 5'd8;
      default: burst_len = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/dma_strobe_det.sv
module dma_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_wr,
  input  logic rd_n,
  input  logic wr_n,
  input  logic dack_n,
  input  logic active,
  output logic xfer,
  output logic stb_high
);
  logic stb_q;
  logic stb;

  assign stb      = sel_wr ? wr_n : rd_n;
  assign stb_high = stb;
  assign xfer     = active & stb_q & ~stb & ~dack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b1;
    else        stb_q <= stb;
  end
endmodule

// File: rtl/dma_burst_track.sv
module dma_burst_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       xfer,
  input  logic [1:0] code,
  input  logic       stb_high,
  output logic       gap_nxt
);
  import dma_pkg::*;

  logic [4:0] bcnt_q, bcnt_d;
  logic       gap_q;
  logic       last;

  assign last = (bcnt_q == burst_len(code) - 5'd1);

  always_comb begin
    bcnt_d  = bcnt_q;
    gap_nxt = gap_q;
    if (clr) begin
      bcnt_d  = '0;
      gap_nxt = 1'b0;
    end else if (xfer) begin
      bcnt_d = last ? 5'd0 : bcnt_q + 5'd1;
      if (last) gap_nxt = 1'b1;
    end else if (stb_high) begin
      gap_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      gap_q  <= 1'b0;
    end else begin
      bcnt_q <= bcnt_d;
      gap_q  <= gap_nxt;
    end
  end
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl #(
  parameter int MAX_PKT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we_i,
  input  logic [4:0] cfg_wdata_i,
  output logic [4:0] cfg_o,
  output logic       dreq_o,
  input  logic       dack_n_i,
  input  logic       rd_n_i,
  input  logic       wr_n_i,
  input  logic       eot_n_i,
  output logic [7:0] mem_rdata_o,
  input  logic [7:0] mem_wdata_i,
  input  logic       buf_ready_i,
  output logic [7:0] buf_addr_o,
  input  logic [7:0] buf_rdata_i,
  output logic       buf_rd_o,
  output logic       buf_wr_o,
  output logic [7:0] buf_wdata_o,
  output logic       buf_validate_o,
  output logic [7:0] buf_len_o,
  output logic       buf_release_o,
  output logic       eot_irq_o,
  input  logic       irq_clr_i
);
  import dma_pkg::*;

  localparam logic [7:0] PKT_LIM = 8'(MAX_PKT);

  dma_st_e    st_q, st_d;
  logic [4:0] cfg_q, cfg_d;
  logic [7:0] cnt_q, cnt_d, len_q, len_d;
  logic       irq_q, irq_d, dreq_q, dreq_d;
  logic       en, dir, autold;
  logic       xfer, stb_high, gap_nxt;
  logic [7:0] cnt_inc, limit;
  logic       eot_hit, lim_hit, finish, zero_len;

  assign en     = cfg_q[2];
  assign dir    = cfg_q[3];
  assign autold = cfg_q[4];

  dma_strobe_det u_stb (
    .clk(clk), .rst_n(rst_n), .sel_wr(dir), .rd_n(rd_n_i), .wr_n(wr_n_i),
    .dack_n(dack_n_i), .active(st_q == ST_MOVE), .xfer(xfer), .stb_high(stb_high)
  );

  dma_burst_track u_burst (
    .clk(clk), .rst_n(rst_n), .clr(finish | cfg_we_i), .xfer(xfer),
    .code(cfg_q[1:0]), .stb_high(stb_high), .gap_nxt(gap_nxt)
  );

  assign cnt_inc  = cnt_q + 8'd1;
  assign limit    = dir ? PKT_LIM : ((len_q > PKT_LIM) ? PKT_LIM : len_q);
  assign eot_hit  = xfer & ~eot_n_i;
  assign lim_hit  = xfer & (cnt_inc == limit);
  assign finish   = eot_hit | lim_hit;
  assign zero_len = (st_q == ST_FETCH) & (buf_rdata_i == 8'd0);

  // buffer side
  assign buf_addr_o     = (st_q == ST_FETCH) ? LEN_OFS : cnt_q + PAY_OFS;
  assign buf_wr_o       = xfer & dir;
  assign buf_rd_o       = xfer & ~dir;
  assign buf_wdata_o    = mem_wdata_i;
  assign mem_rdata_o    = buf_rdata_i;
  assign buf_validate_o = finish & dir;
  assign buf_len_o      = cnt_inc;
  assign buf_release_o  = (lim_hit & ~dir) | zero_len;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    len_d = len_q;
    cfg_d = cfg_q;
    irq_d = irq_q & ~irq_clr_i;
    case (st_q)
      ST_IDLE: if (en && buf_ready_i) st_d = dir ? ST_MOVE : ST_FETCH;
      ST_FETCH: begin
        len_d = buf_rdata_i;
        st_d  = zero_len ? ST_IDLE : ST_MOVE;
      end
      ST_MOVE: begin
        if (xfer) cnt_d = cnt_inc;
        if (finish) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
          irq_d = 1'b1;
          if (!autold) cfg_d[2] = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (cfg_we_i) begin
      cfg_d = cfg_wdata_i;
      st_d  = ST_IDLE;
      cnt_d = '0;
    end
    dreq_d = (st_d == ST_MOVE) & cfg_d[2] & buf_ready_i & ~gap_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      irq_q  <= 1'b0;
      dreq_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cfg_q  <= cfg_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      irq_q  <= irq_d;
      dreq_q <= dreq_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign dreq_o    = dreq_q;
  assign eot_irq_o = irq_q;
endmodule

// File: rtl/dma_burst_ctrl_chk.sv
module dma_burst_ctrl_chk #(
  parameter int MAX_PKT = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we_i,
  input logic [4:0] cfg_o,
  input logic       dreq_o,
  input logic       dack_n_i,
  input logic       buf_wr_o,
  input logic       buf_rd_o,
  input logic       buf_validate_o,
  input logic [7:0] buf_len_o,
  input logic       eot_irq_o,
  input logic       irq_clr_i
);
  assert_req_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_o |-> cfg_o[2]);

  assert_move_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_o || buf_rd_o) |-> !dack_n_i);

  assert_validate_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_validate_o |-> (buf_len_o != 8'd0 && int'(buf_len_o) <= MAX_PKT));

  assert_req_stops_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_validate_o |=> !dreq_o);

  assert_enable_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_validate_o && !cfg_o[4] && !cfg_we_i) |=> !cfg_o[2]);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_irq_o && !irq_clr_i) |=> eot_irq_o);
endmodule

bind dma_burst_ctrl dma_burst_ctrl_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_o(cfg_o), .dreq_o(dreq_o),
  .dack_n_i(dack_n_i), .buf_wr_o(buf_wr_o), .buf_rd_o(buf_rd_o),
  .buf_validate_o(buf_validate_o), .buf_len_o(buf_len_o),
  .eot_irq_o(eot_irq_o), .irq_clr_i(irq_clr_i)
);

// File: tb/test_dma_burst_ctrl.sv
module test_dma_burst_ctrl;
  localparam int MAXP = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we_i = 1'b0;
  logic [4:0] cfg_wdata_i = '0;
  logic [4:0] cfg_o;
  logic       dreq_o;
  logic       dack_n_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1, eot_n_i = 1'b1;
  logic [7:0] mem_rdata_o;
  logic [7:0] mem_wdata_i = '0;
  logic       buf_ready_i = 1'b0;
  logic [7:0] buf_addr_o, buf_rdata_i, buf_wdata_o, buf_len_o;
  logic       buf_rd_o, buf_wr_o, buf_validate_o, buf_release_o, eot_irq_o;
  logic       irq_clr_i = 1'b0;

  logic [7:0] bufmem [0:MAXP+1];
  assign buf_rdata_i = (int'(buf_addr_o) <= MAXP + 1) ? bufmem[buf_addr_o] : 8'h00;

  int n_tests = 0, n_fail = 0, cycles = 0, rel_cnt = 0, dreq_cnt = 0;
  bit done = 0;

  // captured combinational outputs of the last strobe
  logic       s_wr, s_rd, s_val, s_rel;
  logic [7:0] s_addr, s_rdata, s_len;

  dma_burst_ctrl #(.MAX_PKT(MAXP)) i_dma_burst_ctrl (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (buf_release_o) rel_cnt <= rel_cnt + 1;
    if (dreq_o) dreq_cnt <= dreq_cnt + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [4:0] v);
    @(negedge clk); cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk); cfg_we_i = 1'b0;
  endtask

  task automatic wait_dreq(input string tag);
    int k = 0;
    while (!dreq_o && k < 20) begin @(negedge clk); k++; end
    check(tag, dreq_o, 1);
  endtask

  // one strobe cycle; returns at the negedge after the sampling edge
  task automatic strobe(input bit wr, input bit ack, input logic [7:0] d, input bit eot);
    @(negedge clk);
    dack_n_i = ~ack; eot_n_i = ~eot; mem_wdata_i = d;
    if (wr) wr_n_i = 1'b0; else rd_n_i = 1'b0;
    #1;
    s_wr = buf_wr_o; s_rd = buf_rd_o; s_val = buf_validate_o; s_rel = buf_release_o;
    s_addr = buf_addr_o; s_rdata = mem_rdata_o; s_len = buf_len_o;
    @(negedge clk);
    dack_n_i = 1'b1; eot_n_i = 1'b1; wr_n_i = 1'b1; rd_n_i = 1'b1;
  endtask

  task automatic t_reset;
    check("R10 reset cfg", cfg_o, 0);
    check("R2 reset dreq", dreq_o, 0);
    check("R8 reset irq", eot_irq_o, 0);
  endtask

  task automatic t_write_burst_fill;
    buf_ready_i = 1'b1;
    write_cfg(5'b01101);               // dir 1, en, burst of 4
    check("R10 cfg readback", cfg_o, 5'b01101);
    for (int i = 0; i < MAXP; i++) begin
      if (i % 4 == 0) wait_dreq("R1 request at burst start");
      strobe(1, 1, 8'(i + 8'h30), 0);
      check("R3 byte written", s_wr, 1);
      check("R4 payload address", s_addr, i + 2);
      check("R3 write data", s_len == 8'(i + 1) ? 1 : 0, 1);
      if (i % 4 == 3) begin
        check("R1 request low after last of burst", dreq_o, 0);
        if (i != MAXP - 1) begin
          @(negedge clk);
          check("R1 request back after strobe release", dreq_o, 1);
        end
      end else begin
        check("R1 request held within burst", dreq_o, 1);
      end
      if (i == MAXP - 1) begin
        check("R5 validate at max", s_val, 1);
        check("R5 length at max", s_len, MAXP);
      end else if (s_val) begin
        check("R5 early validate", s_val, 0);
      end
    end
    check("R7 enable cleared", cfg_o[2], 0);
    check("R8 flag set", eot_irq_o, 1);
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
    check("R8 flag cleared", eot_irq_o, 0);
  endtask

  task automatic t_ignored_and_eot;
    write_cfg(5'b01100);               // dir 1, en, single
    wait_dreq("R2 request with ready");
    strobe(1, 0, 8'h55, 0);            // ack high: ignored
    check("R3 no write without ack", s_wr, 0);
    check("R3 request unchanged", dreq_o, 1);
    for (int i = 0; i < 3; i++) begin
      wait_dreq("R1 single request");
      strobe(1, 1, 8'(8'hA0 + i), i == 2);
      check("R3 address not advanced by ignored strobe", s_addr, i + 2);
      check("R1 single mode drops request", dreq_o, 0);
    end
    check("R6 validate on terminate", s_val, 1);
    check("R6 partial length", s_len, 3);
    check("R7 enable cleared by terminate", cfg_o[2], 0);
    check("R8 flag on terminate", eot_irq_o, 1);
    repeat (3) @(negedge clk);
    check("R7 no restart", dreq_o, 0);
  endtask

  task automatic t_autoreload_and_ready;
    write_cfg(5'b11100);               // auto, dir 1, en, single
    wait_dreq("R7 first request");
    strobe(1, 1, 8'h11, 1);
    check("R6 terminate validates one", s_len, 1);
    check("R7 enable kept", cfg_o[2], 1);
    wait_dreq("R7 request restarts");
    strobe(1, 1, 8'h12, 0);
    check("R7 count restarted", s_addr, 2);
    @(negedge clk); buf_ready_i = 1'b0;
    @(negedge clk);
    check("R2 request needs ready", dreq_o, 0);
    buf_ready_i = 1'b1;
    wait_dreq("R2 request with ready again");
  endtask

  task automatic t_read;
    bufmem[0] = 8'hEE; bufmem[1] = 8'd5;
    for (int i = 0; i < 5; i++) bufmem[2 + i] = 8'(8'hC0 + i);
    buf_ready_i = 1'b1;
    write_cfg(5'b00110);               // dir 0, en, burst of 8
    wait_dreq("R9 request after length fetch");
    for (int i = 0; i < 5; i++) begin
      strobe(0, 1, 8'h00, 0);
      check("R3 byte read", s_rd, 1);
      check("R4 read address", s_addr, i + 2);
      check("R9 read data", s_rdata, 8'hC0 + i);
      check("R9 release timing", s_rel, i == 4 ? 1 : 0);
    end
    check("R9 request ends after length", dreq_o, 0);
    check("R8 flag after read", eot_irq_o, 1);
    buf_ready_i = 1'b0;
    check("R7 enable cleared after read", cfg_o[2], 0);
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
  endtask

  task automatic t_zero_len;
    int r0, d0, k;
    bufmem[1] = 8'd0;
    r0 = rel_cnt; d0 = dreq_cnt; k = 0;
    write_cfg(5'b00100);
    buf_ready_i = 1'b1;
    while (rel_cnt == r0 && k < 20) begin @(negedge clk); k++; end
    buf_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 zero length released once", rel_cnt - r0, 1);
    check("R9 zero length no request", dreq_cnt - d0, 0);
    check("R9 zero length no flag", eot_irq_o, 0);
  endtask

  initial begin
    for (int i = 0; i <= MAXP + 1; i++) bufmem[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_burst_fill();
    t_ignored_and_eot();
    t_autoreload_and_ready();
    t_read();
    t_zero_len();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(negedge clk) begin
    if (!done && cycles > 100000) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule